// File: doc/BRIEF.md
# SPI Queue Register Front End

This block sits between a 32-bit register bus and the serial engine of an SPI controller. It holds two byte queues: one carries bytes from software to the engine, and the other carries bytes from the engine back to software. Software can reach each queue one byte per access or four bytes per access. Four-byte accesses use their own pair of data addresses. The engine side trades single bytes over valid/ready handshakes.

Next to the queues, the block holds several registers. A control word and a frame description are kept here and handed to the engine, together with a 16-bit upper frame count. The block also has an interrupt mask and a status word. The status word mixes sticky event flags, which software clears by writing ones, with live queue conditions. A registered interrupt line is raised whenever an enabled low status flag is set. Software polls the ready flag before it starts a new frame. The serial shifting itself belongs to the engine and is not part of this block.

A bus read returns its data on `reg_rdata` in the clock after `reg_rd` is sampled. Reading one of the receive data addresses removes the returned bytes from the queue.

Top module: `spiq_front`

## Requirements
- R1: After reset the control, frame, upper count and interrupt mask registers read 0, `irq` is 0, and the status word reads 0x98 while `eng_busy` is low (transmit space at bit 3, receive empty at bit 4, ready at bit 7).
- R2: A write to offset 0x44 appends bits 7:0 to the transmit queue. Queued bytes appear on `tx_out_data` in write order. `tx_out_valid` stays low while control bit 0 (enable) is clear. A byte is held stable until `tx_out_ready` takes it.
- R3: A write to offset 0x4C appends four bytes, with bits 7:0 first and bits 31:24 last.
- R4: A read of offset 0x40 removes one byte and returns it in bits 7:0. A read of an empty receive queue returns 0 and has no other effect.
- R5: A read of offset 0x48 removes four bytes and returns the oldest in bits 7:0 and the newest in bits 31:24.
- R6: A four-byte transmit write with fewer than 4 free entries, or a four-byte receive read with fewer than 4 stored bytes, leaves the queue unchanged and sets sticky status bit 6. Such a read returns 0.
- R7: Status bit 0 (transmit done) is set by a pulse on `eng_tx_done`, bit 1 (receive done) by a pulse on `eng_rx_done`, and bit 2 (receive available) each time the engine delivers a byte. Writing 1 to bit 0, 1, 2 or 6 at offset 0x10 clears that bit, and writing 0 leaves it alone. If a set and a clear arrive in the same cycle, the set wins.
- R8: Status bits 3 (transmit not full), 4 (receive empty) and 5 (transmit full) follow the queue levels. Bit 7 is the inverse of `eng_busy`. Bit 8 mirrors control bit 16 (four-byte access flag).
- R9: `irq` is high one clock after any of status bits 5:0 is set together with the same bit of the interrupt mask at offset 0x0C, and low one clock after none is.
- R10: Control (0x00) and frame (0x04) read back all 32 bits written. The upper count (0x50) keeps bits 15:0 and the mask keeps bits 5:0. These registers drive `cfg_ctrl`, `cfg_frame` and `cfg_upper`.
- R11: A one-byte write to a full transmit queue is dropped. `rx_in_ready` is low while the receive queue holds DEPTH bytes, so a byte offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after `reg_rd` |
| tx_out_valid | output | 1 | Transmit byte offered to the engine |
| tx_out_data | output | 8 | Transmit byte |
| tx_out_ready | input | 1 | Engine takes the transmit byte |
| rx_in_valid | input | 1 | Engine offers a received byte |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Receive queue can take a byte |
| eng_tx_done | input | 1 | One-clock pulse: engine finished sending |
| eng_rx_done | input | 1 | One-clock pulse: engine finished receiving |
| eng_busy | input | 1 | Engine is in a frame |
| cfg_ctrl | output | 32 | Control register contents |
| cfg_frame | output | 32 | Frame register contents |
| cfg_upper | output | 16 | Upper frame count |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with DEPTH = 8. With that depth, both queues can be filled in a handful of accesses. This brings the full and empty edges within easy reach: a dropped byte write, a refused engine byte, and four-byte accesses rejected for lack of room or data. The depth is also not a multiple of the word accesses' alignment once single bytes are mixed in. As a result, the four-byte pushes and pops wrap around the end of the storage at odd positions, so the little-endian byte order is checked across the wrap.

// File: rtl/spiq_pkg.sv
`timescale 1ns/1ps
package spiq_pkg;
  // Register offsets on the byte-addressed bus
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_FRAME = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_RXB   = 8'h40;
  localparam logic [7:0] OFS_TXB   = 8'h44;
  localparam logic [7:0] OFS_RXW   = 8'h48;
  localparam logic [7:0] OFS_TXW   = 8'h4C;
  localparam logic [7:0] OFS_UPPER = 8'h50;

  // Status bit positions
  localparam int ST_TXDONE = 0;
  localparam int ST_RXDONE = 1;
  localparam int ST_RXAV   = 2;
  localparam int ST_TXSPC  = 3;
  localparam int ST_RXEMP  = 4;
  localparam int ST_TXFUL  = 5;
  localparam int ST_ERR    = 6;
  localparam int ST_RDY    = 7;
  localparam int ST_X4     = 8;

  localparam int STAT_W = 9;
  localparam int IEN_W  = 6;
  localparam int CTRL_X4_BIT = 16;
  localparam int CTRL_EN_BIT = 0;
endpackage

// File: rtl/spiq_fifo.sv
`timescale 1ns/1ps
// Byte queue that can take or give up to four bytes per clock.
// The caller must only request a push that fits and a pop that is covered.
module spiq_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    push_n,
  input  logic [31:0]   push_data,
  input  logic [2:0]    pop_n,
  output logic [31:0]   peek,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + AW'(push_n);
      rp  <= rp + AW'(pop_n);
      cnt <= cnt + CW'(push_n) - CW'(pop_n);
    end
  end

  // Storage without reset so it can map onto distributed memory
  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (k < int'(push_n)) mem[wp + AW'(k)] <= push_data[8*k +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) peek[8*k +: 8] = mem[rp + AW'(k)];
  end

  assign count = cnt;
endmodule

// File: rtl/spiq_regs.sv
`timescale 1ns/1ps
module spiq_regs
  import spiq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CW-1:0]     tx_cnt,
  input  logic [CW-1:0]     rx_cnt,
  input  logic [31:0]       rx_peek,
  output logic [2:0]        tx_push_n,
  output logic [31:0]       tx_push_data,
  output logic [2:0]        rx_pop_n,
  input  logic              rx_push,
  input  logic              eng_tx_done,
  input  logic              eng_rx_done,
  input  logic              eng_busy,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       frame_q,
  output logic [15:0]       upper_q,
  output logic [IEN_W-1:0]  ien_q,
  output logic [STAT_W-1:0] stat_vec,
  output logic              irq
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] FOUR_C  = CW'(4);

  logic wr_txb, wr_txw, rd_rxb, rd_rxw, wr_stat;
  logic tx_byte_ok, tx_word_ok, rx_byte_ok, rx_word_ok, err_set;
  logic tx_done_q, rx_done_q, rx_av_q, err_q;
  logic [CW-1:0] tx_free;

  assign wr_txb  = reg_wr && (reg_addr == OFS_TXB);
  assign wr_txw  = reg_wr && (reg_addr == OFS_TXW);
  assign rd_rxb  = reg_rd && (reg_addr == OFS_RXB);
  assign rd_rxw  = reg_rd && (reg_addr == OFS_RXW);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);

  assign tx_free    = DEPTH_C - tx_cnt;
  assign tx_byte_ok = wr_txb && (tx_cnt != DEPTH_C);
  assign tx_word_ok = wr_txw && (tx_free >= FOUR_C);
  assign rx_byte_ok = rd_rxb && (rx_cnt != '0);
  assign rx_word_ok = rd_rxw && (rx_cnt >= FOUR_C);
  assign err_set    = (wr_txw && !tx_word_ok) || (rd_rxw && !rx_word_ok);

  always_comb begin
    tx_push_n    = tx_word_ok ? 3'd4 : (tx_byte_ok ? 3'd1 : 3'd0);
    tx_push_data = wr_txw ? reg_wdata : {24'h0, reg_wdata[7:0]};
    rx_pop_n     = rx_word_ok ? 3'd4 : (rx_byte_ok ? 3'd1 : 3'd0);
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      frame_q <= '0;
      upper_q <= '0;
      ien_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL:  ctrl_q  <= reg_wdata;
        OFS_FRAME: frame_q <= reg_wdata;
        OFS_UPPER: upper_q <= reg_wdata[15:0];
        OFS_IEN:   ien_q   <= reg_wdata[IEN_W-1:0];
        default: ;
      endcase
    end
  end

  // Sticky flags: a set in the same clock as a clear wins
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      rx_av_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      tx_done_q <= eng_tx_done | (tx_done_q & ~(wr_stat & reg_wdata[ST_TXDONE]));
      rx_done_q <= eng_rx_done | (rx_done_q & ~(wr_stat & reg_wdata[ST_RXDONE]));
      rx_av_q   <= rx_push     | (rx_av_q   & ~(wr_stat & reg_wdata[ST_RXAV]));
      err_q     <= err_set     | (err_q     & ~(wr_stat & reg_wdata[ST_ERR]));
    end
  end

  always_comb begin
    stat_vec            = '0;
    stat_vec[ST_TXDONE] = tx_done_q;
    stat_vec[ST_RXDONE] = rx_done_q;
    stat_vec[ST_RXAV]   = rx_av_q;
    stat_vec[ST_TXSPC]  = (tx_cnt != DEPTH_C);
    stat_vec[ST_RXEMP]  = (rx_cnt == '0);
    stat_vec[ST_TXFUL]  = (tx_cnt == DEPTH_C);
    stat_vec[ST_ERR]    = err_q;
    stat_vec[ST_RDY]    = ~eng_busy;
    stat_vec[ST_X4]     = ctrl_q[CTRL_X4_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_vec[IEN_W-1:0] & ien_q);
  end

  // Registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL:  reg_rdata <= ctrl_q;
        OFS_FRAME: reg_rdata <= frame_q;
        OFS_UPPER: reg_rdata <= {16'h0, upper_q};
        OFS_IEN:   reg_rdata <= {{(32-IEN_W){1'b0}}, ien_q};
        OFS_STAT:  reg_rdata <= {{(32-STAT_W){1'b0}}, stat_vec};
        OFS_RXB:   reg_rdata <= rx_byte_ok ? {24'h0, rx_peek[7:0]} : 32'h0;
        OFS_RXW:   reg_rdata <= rx_word_ok ? rx_peek : 32'h0;
        default:   reg_rdata <= 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/spiq_front.sv
`timescale 1ns/1ps
module spiq_front
  import spiq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_out_valid,
  output logic [7:0]  tx_out_data,
  input  logic        tx_out_ready,
  input  logic        rx_in_valid,
  input  logic [7:0]  rx_in_data,
  output logic        rx_in_ready,
  input  logic        eng_tx_done,
  input  logic        eng_rx_done,
  input  logic        eng_busy,
  output logic [31:0] cfg_ctrl,
  output logic [31:0] cfg_frame,
  output logic [15:0] cfg_upper,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic [31:0]       tx_peek, rx_peek, tx_push_data;
  logic [2:0]        tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [STAT_W-1:0] stat_vec;
  logic [IEN_W-1:0]  ien_q;
  logic              rx_push;

  assign tx_out_valid = cfg_ctrl[CTRL_EN_BIT] && (tx_cnt != '0);
  assign tx_out_data  = tx_peek[7:0];
  assign tx_pop_n     = (tx_out_valid && tx_out_ready) ? 3'd1 : 3'd0;

  assign rx_in_ready  = (rx_cnt != DEPTH_C);
  assign rx_push      = rx_in_valid && rx_in_ready;
  assign rx_push_n    = rx_push ? 3'd1 : 3'd0;

  spiq_fifo #(.DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push_n(tx_push_n), .push_data(tx_push_data),
    .pop_n(tx_pop_n), .peek(tx_peek), .count(tx_cnt)
  );

  spiq_fifo #(.DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push_n(rx_push_n), .push_data({24'h0, rx_in_data}),
    .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt)
  );

  spiq_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_peek(rx_peek),
    .tx_push_n(tx_push_n), .tx_push_data(tx_push_data), .rx_pop_n(rx_pop_n),
    .rx_push(rx_push), .eng_tx_done(eng_tx_done), .eng_rx_done(eng_rx_done),
    .eng_busy(eng_busy),
    .ctrl_q(cfg_ctrl), .frame_q(cfg_frame), .upper_q(cfg_upper),
    .ien_q(ien_q), .stat_vec(stat_vec), .irq(irq)
  );
endmodule

// File: rtl/spiq_front_chk.sv
`timescale 1ns/1ps
module spiq_front_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [7:0]    tx_out_data,
  input logic          rx_in_ready,
  input logic          eng_tx_done,
  input logic [31:0]   cfg_ctrl,
  input logic [8:0]    stat_vec,
  input logic [5:0]    ien_q,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          irq
);
  a_r2_gate_off: assert property (@(posedge clk) disable iff (rst)
    !cfg_ctrl[0] |-> !tx_out_valid);

  a_r2_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid || !cfg_ctrl[0]));

  a_r2_hold_data: assert property (@(posedge clk) disable iff (rst)
    (tx_out_valid && !tx_out_ready) |=> $stable(tx_out_data));

  a_r11_rx_refuse: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == CW'(DEPTH)) |-> !rx_in_ready);

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  a_r7_txdone_set: assert property (@(posedge clk) disable iff (rst)
    eng_tx_done |=> stat_vec[0]);

  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|(stat_vec[5:0] & ien_q)) |=> irq);

  a_r9_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_vec[5:0] & ien_q)) |=> !irq);
endmodule

bind spiq_front spiq_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_data(tx_out_data), .rx_in_ready(rx_in_ready),
  .eng_tx_done(eng_tx_done), .cfg_ctrl(cfg_ctrl),
  .stat_vec(stat_vec), .ien_q(ien_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .irq(irq)
);

// File: tb/sim_spiq_front.sv
`timescale 1ns/1ps
module sim_spiq_front;
  localparam int DEPTH = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_FRAME = 8'h04, A_IEN = 8'h0C,
    A_STAT = 8'h10, A_RXB = 8'h40, A_TXB = 8'h44, A_RXW = 8'h48,
    A_TXW = 8'h4C, A_UPPER = 8'h50;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_out_valid, tx_out_ready = 0;
  logic [7:0] tx_out_data;
  logic rx_in_valid = 0, rx_in_ready;
  logic [7:0] rx_in_data = 0;
  logic eng_tx_done = 0, eng_rx_done = 0, eng_busy = 0;
  logic [31:0] cfg_ctrl, cfg_frame;
  logic [15:0] cfg_upper;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] sb[$];
  logic [31:0] rd;

  always #2 clk = ~clk;

  spiq_front #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  // Driver: queue expected bytes, then write them
  task automatic send_byte(input logic [7:0] b);
    sb.push_back(b);
    bus_wr(A_TXB, {24'h0, b});
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) sb.push_back(w[8*k +: 8]);
    bus_wr(A_TXW, w);
  endtask

  task automatic eng_byte(input logic [7:0] b);
    @(negedge clk); rx_in_valid = 1; rx_in_data = b;
    @(negedge clk); rx_in_valid = 0;
  endtask

  task automatic pulse_tx_done();
    @(negedge clk); eng_tx_done = 1;
    @(negedge clk); eng_tx_done = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: every byte taken by the engine is compared with the scoreboard
  always @(negedge clk) begin
    if (!rst && tx_out_valid && tx_out_ready) begin
      if (sb.size() == 0) chk("R2 R11 unexpected transmit byte", {24'h0, tx_out_data}, 32'h0);
      else chk("R2 R3 transmit order", {24'h0, tx_out_data}, {24'h0, sb.pop_front()});
    end
  end

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3); rst = 0; idle(1);
    // R1 reset state
    bus_rd(A_STAT, rd); chk("R1 status", rd, 32'h98);
    bus_rd(A_CTRL, rd); chk("R1 ctrl", rd, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R10 readback
    bus_wr(A_FRAME, 32'hA5A5_1234); bus_rd(A_FRAME, rd); chk("R10 frame", rd, 32'hA5A5_1234);
    bus_wr(A_UPPER, 32'hFFFF_ABCD); bus_rd(A_UPPER, rd); chk("R10 upper", rd, 32'h0000_ABCD);
    chk("R10 cfg_upper", {16'h0, cfg_upper}, 32'h0000_ABCD);
    bus_wr(A_IEN, 32'hFFFF_FFFF); bus_rd(A_IEN, rd); chk("R10 ien", rd, 32'h3F);
    bus_wr(A_IEN, 32'h0);

    // R2 enable gating, then flow
    tx_out_ready = 1;
    send_byte(8'h11); idle(4);
    chk("R2 held while disabled", {31'h0, tx_out_valid}, 32'h0);
    bus_wr(A_CTRL, 32'h0001_0003); bus_rd(A_CTRL, rd); chk("R10 ctrl", rd, 32'h0001_0003);
    idle(4); chk("R2 drained", sb.size(), 0);
    // R3 word order, mixed with bytes so pointers wrap unaligned
    send_byte(8'h55); send_word(32'h4433_2211); send_byte(8'h66);
    send_word(32'hD4C3_B2A1); send_word(32'h0807_0605);
    idle(20); chk("R3 word bytes drained", sb.size(), 0);

    // R11 transmit full, R6 word refused
    tx_out_ready = 0;
    for (int i = 0; i < DEPTH; i++) send_byte(8'h60 + 8'(i));
    bus_rd(A_STAT, rd);
    chk("R8 tx full bit5", {31'h0, rd[5]}, 32'h1);
    chk("R8 tx space bit3", {31'h0, rd[3]}, 32'h0);
    bus_wr(A_TXB, 32'hEE);
    bus_wr(A_TXW, 32'hDEAD_BEEF);
    bus_rd(A_STAT, rd); chk("R6 error on tx word", {31'h0, rd[6]}, 32'h1);
    bus_wr(A_STAT, 32'h40);
    bus_rd(A_STAT, rd); chk("R7 error cleared", {31'h0, rd[6]}, 32'h0);
    tx_out_ready = 1; idle(20);
    chk("R11 only queued bytes sent", sb.size(), 0);
    chk("R11 queue idle", {31'h0, tx_out_valid}, 32'h0);

    // R4 receive byte path
    eng_byte(8'hA1);
    bus_rd(A_STAT, rd);
    chk("R7 rx avail set", {31'h0, rd[2]}, 32'h1);
    chk("R8 rx not empty", {31'h0, rd[4]}, 32'h0);
    bus_rd(A_RXB, rd); chk("R4 byte read", rd, 32'hA1);
    bus_rd(A_RXB, rd); chk("R4 empty read", rd, 32'h0);
    bus_rd(A_STAT, rd); chk("R8 rx empty", {31'h0, rd[4]}, 32'h1);
    // R5 word read, R6 short word read
    for (int i = 1; i <= 5; i++) eng_byte(8'hB0 + 8'(i));
    bus_rd(A_RXW, rd); chk("R5 word read", rd, 32'hB4B3_B2B1);
    bus_rd(A_RXW, rd); chk("R6 short word read", rd, 32'h0);
    bus_rd(A_STAT, rd); chk("R6 error on rx word", {31'h0, rd[6]}, 32'h1);
    bus_rd(A_RXB, rd); chk("R6 byte left intact", rd, 32'hB5);
    bus_wr(A_STAT, 32'h44);

    // R11 receive full
    for (int i = 0; i < DEPTH; i++) eng_byte(8'hC0 + 8'(i));
    chk("R11 rx_in_ready low", {31'h0, rx_in_ready}, 32'h0);
    eng_byte(8'hCF);
    for (int i = 0; i < DEPTH; i++) begin
      bus_rd(A_RXB, rd); chk("R11 R4 rx order", rd, 32'hC0 + i);
    end
    bus_rd(A_RXB, rd); chk("R11 refused byte absent", rd, 32'h0);
    bus_wr(A_STAT, 32'h47);

    // R7 sticky W1C and set priority
    pulse_tx_done();
    bus_rd(A_STAT, rd); chk("R7 tx done set", {31'h0, rd[0]}, 32'h1);
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_STAT, rd); chk("R7 write zero keeps", {31'h0, rd[0]}, 32'h1);
    bus_wr(A_STAT, 32'h1);
    bus_rd(A_STAT, rd); chk("R7 tx done cleared", {31'h0, rd[0]}, 32'h0);
    @(negedge clk); reg_wr = 1; reg_addr = A_STAT; reg_wdata = 32'h2; eng_rx_done = 1;
    @(negedge clk); reg_wr = 0; eng_rx_done = 0;
    bus_rd(A_STAT, rd); chk("R7 set beats clear", {31'h0, rd[1]}, 32'h1);
    bus_wr(A_STAT, 32'h2);
    bus_rd(A_STAT, rd); chk("R7 rx done cleared", {31'h0, rd[1]}, 32'h0);

    // R8 ready and x4 mirror
    eng_busy = 1;
    bus_rd(A_STAT, rd); chk("R8 not ready", {31'h0, rd[7]}, 32'h0);
    eng_busy = 0;
    bus_rd(A_STAT, rd); chk("R8 ready", {31'h0, rd[7]}, 32'h1);
    chk("R8 x4 mirror set", {31'h0, rd[8]}, 32'h1);
    bus_wr(A_CTRL, 32'h3);
    bus_rd(A_STAT, rd); chk("R8 x4 mirror clear", {31'h0, rd[8]}, 32'h0);

    // R9 interrupt
    bus_wr(A_IEN, 32'h01); idle(1);
    chk("R9 irq idle", {31'h0, irq}, 32'h0);
    pulse_tx_done(); idle(1);
    chk("R9 irq raised", {31'h0, irq}, 32'h1);
    bus_wr(A_STAT, 32'h1); idle(1);
    chk("R9 irq dropped", {31'h0, irq}, 32'h0);
    bus_wr(A_IEN, 32'h10); idle(1);
    chk("R9 irq on live flag", {31'h0, irq}, 32'h1);
    bus_wr(A_IEN, 32'h0); idle(1);
    chk("R9 irq masked", {31'h0, irq}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule